// File: doc/BRIEF.md
# Flash Program/Erase Suspend-Resume Controller

This block is the status and control part of a serial flash slave that can pause a long internal program or erase operation and later continue it. Command bytes arrive serially on `si_i`. They are framed by the active-low select `cs_ni` and sampled on rising `sclk_i`. All three pins are resynchronised into the `clk_i` domain. The block keeps two status bits. `wip_o` shows that an operation is in progress. `sus_o` shows that an operation is parked.

The internal operation is modelled by a down-counter. A pulse on `op_start_i` loads it with `op_len_i` cycles of work. A pause opcode freezes the counter and, after a settling delay, parks the operation. A continue opcode is honoured only while the operation is parked. It clears the parked bit at once and brings the busy bit back after a short, bounded delay. The counter then carries on from the value it held when it was frozen.

Top module: `flash_susp_ctrl`

## Requirements
- R1: A command is a byte shifted in MSB first on rising `sclk_i` while `cs_ni` is low. It acts on the third rising `clk_i` edge after `cs_ni` rises, and only if exactly 8 bits were clocked. The pause opcode is 0x75 and the continue opcode is 0x7A. Any other byte, and any frame of 7 or 9 bits, has no effect.
- R2: When idle, `op_start_i` with a nonzero `op_len_i` raises `wip_o` on the next cycle. `wip_o` stays high for `op_len_i` cycles and then falls in the same cycle as a one-cycle `done_o` pulse. A start while not idle, or a start with length zero, is ignored.
- R3: A pause command accepted while the operation runs freezes the work counter. `wip_o` stays 1 and `sus_o` stays 0 for `TSUS_CYC` cycles. After that, `wip_o` is 0 and `sus_o` is 1.
- R4: A pause command that arrives while `wip_o` is 0 has no effect. This covers the idle state and the parked state.
- R5: A continue command is accepted only when `sus_o` is 1 and `wip_o` is 0. On acceptance, `sus_o` is 0 from the next cycle. `wip_o` stays 0 for the resume delay and then returns to 1.
- R6: Across any number of pause/continue pairs, the operation consumes exactly `op_len_i` running cycles. Over the whole operation, `wip_o` is high for `op_len_i` cycles plus `TSUS_CYC` cycles for each pause.
- R7: A continue command that arrives while no pause is active has no effect on either status bit or on the work counter.
- R8: If a pause command takes effect in the same cycle that the work counter finishes, completion wins. `done_o` pulses, and the pause is dropped, so `sus_o` stays 0.
- R9: The resume delay is the smaller of `RES_DLY_CYC` and floor(200000 / `CLK_PS`) cycles, so it never exceeds 200 ns.
- R10: During and right after reset, `wip_o`, `sus_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial command clock |
| cs_ni | input | 1 | Active-low command frame select |
| si_i | input | 1 | Serial command data, MSB first |
| op_start_i | input | 1 | Starts the modelled program/erase operation |
| op_len_i | input | LEN_W | Operation length in clock cycles |
| wip_o | output | 1 | Operation in progress |
| sus_o | output | 1 | Operation parked |
| done_o | output | 1 | One-cycle pulse when the operation completes |

## Verification
Two functions can land in the same clock edge: the work counter reaching its last cycle and a pause command taking effect. The bench arranges this by shifting a full pause byte with select still low, then starting a 3-cycle operation. Select is raised one cycle later, which puts the command edge exactly on the completion edge. It then judges that `done_o` pulses, that `wip_o` falls, and that `sus_o` never rises. A 4-cycle variant lands the pause one cycle before the end and must park the operation instead. A cycle-level reference model in the bench follows the same rules through the random mix and compares all three outputs on every cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned CMD_W = 8;
  localparam logic [CMD_W-1:0] OP_PAUSE  = 8'h75;
  localparam logic [CMD_W-1:0] OP_RESUME = 8'h7A;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSY,
    ST_PAUSING,
    ST_PARKED,
    ST_RESUMING
  } fsr_state_e;
endpackage

// File: rtl/fsr_cmd_rx.sv
module fsr_cmd_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_BITS    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                si_i,
  output logic                cmd_valid_o,
  output logic [CMD_BITS-1:0] cmd_code_o
);
  localparam int CNT_W = $clog2(CMD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CMD_BITS + 1);
  localparam int TAP = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   sclk_q, cs_q;
  logic [SYNC_STAGES-1:0] si_q;
  logic [CMD_BITS-1:0]    shreg_q;
  logic [CNT_W-1:0]       cnt_q;
  logic sclk_rise, cs_rise, cs_fall, cs_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      cs_q   <= '1;
      si_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk_i};
      cs_q   <= {cs_q[SYNC_STAGES-1:0], cs_ni};
      si_q   <= {si_q[SYNC_STAGES-2:0], si_i};
    end
  end

  assign sclk_rise = sclk_q[TAP] & ~sclk_q[TAP+1];
  assign cs_rise   = cs_q[TAP] & ~cs_q[TAP+1];
  assign cs_fall   = ~cs_q[TAP] & cs_q[TAP+1];
  assign cs_sel    = ~cs_q[TAP];

  // count saturates one past a full byte so over-long frames are rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (cs_fall || cs_rise) begin
      cnt_q <= '0;
    end else if (sclk_rise && cs_sel) begin
      shreg_q <= {shreg_q[CMD_BITS-2:0], si_q[TAP]};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cmd_valid_o = cs_rise && (cnt_q == CNT_FULL);
  assign cmd_code_o  = shreg_q;

  // R1
  frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (cnt_q == '0));
endmodule

// File: rtl/fsr_engine.sv
module fsr_engine #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             run_i,
  output logic             last_o,
  output logic             done_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      done_o <= 1'b0;
    end else begin
      if (load_i) rem_q <= len_i;
      else if (run_i && rem_q != '0) rem_q <= rem_q - LEN_W'(1);
      done_o <= last_o;
    end
  end

  assign last_o = run_i && (rem_q == LEN_W'(1));

  // R3
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(rem_q));

  // R6
  run_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (rem_q != '0));

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run_i);
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int TSUS_CYC = 20,
  parameter int TRES_CYC = 40,
  parameter int LEN_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             last_i,
  output logic             load_o,
  output logic             run_o,
  output logic             wip_o,
  output logic             sus_o
);
  localparam int WMAX = (TSUS_CYC > TRES_CYC) ? TSUS_CYC : TRES_CYC;
  localparam int WC_W = $clog2(WMAX + 1);
  localparam logic [WC_W-1:0] WC_SUS = WC_W'(TSUS_CYC);
  localparam logic [WC_W-1:0] WC_RES = WC_W'(TRES_CYC);
  localparam logic [WC_W-1:0] WC_ONE = WC_W'(1);

  fsr_state_e       st_q, st_d;
  logic [WC_W-1:0]  wc_q, wc_d;
  logic             is_pause, is_resume;

  assign is_pause  = cmd_valid_i && (cmd_code_i == OP_PAUSE);
  assign is_resume = cmd_valid_i && (cmd_code_i == OP_RESUME);

  always_comb begin
    st_d   = st_q;
    wc_d   = wc_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i && len_i != '0) begin
        load_o = 1'b1;
        st_d   = ST_BUSY;
      end
      // completion outranks a pause landing on the same edge
      ST_BUSY: if (last_i) st_d = ST_IDLE;
               else if (is_pause) begin
                 st_d = ST_PAUSING;
                 wc_d = WC_SUS;
               end
      ST_PAUSING: if (wc_q == WC_ONE) st_d = ST_PARKED;
                  else wc_d = wc_q - WC_ONE;
      ST_PARKED: if (is_resume) begin
        st_d = ST_RESUMING;
        wc_d = WC_RES;
      end
      ST_RESUMING: if (wc_q == WC_ONE) st_d = ST_BUSY;
                   else wc_d = wc_q - WC_ONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      wc_q <= '0;
    end else begin
      st_q <= st_d;
      wc_q <= wc_d;
    end
  end

  assign run_o = (st_q == ST_BUSY);
  assign wip_o = (st_q == ST_BUSY) || (st_q == ST_PAUSING);
  assign sus_o = (st_q == ST_PARKED);

  // R5
  res_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_resume && sus_o && !wip_o) |=> (!sus_o && !wip_o));

  // R7
  res_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_resume && st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE));

  // R4
  pause_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pause && sus_o && !is_resume) |=> sus_o);

  // R4
  pause_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pause && st_q == ST_IDLE) |=> !sus_o);

  // R8
  race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && last_i && is_pause) |=> (st_q == ST_IDLE));

  // R3
  park_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sus_o) |-> ($past(st_q) == ST_PAUSING));

  // R3
  wait_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSING || st_q == ST_RESUMING) |-> (wc_q != '0 && wc_q <= WC_W'(WMAX)));
endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
  import fsr_pkg::*;
#(
  parameter int TSUS_CYC    = 20,
  parameter int RES_DLY_CYC = 40,
  parameter int CLK_PS      = 4000,
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             si_i,
  input  logic             op_start_i,
  input  logic [LEN_W-1:0] op_len_i,
  output logic             wip_o,
  output logic             sus_o,
  output logic             done_o
);
  // resume delay is clamped so the busy bit returns within 200 ns
  localparam int RES_LIM_RAW = 200000 / CLK_PS;
  localparam int RES_LIM     = (RES_LIM_RAW < 1) ? 1 : RES_LIM_RAW;
  localparam int RES_EFF0    = (RES_DLY_CYC < RES_LIM) ? RES_DLY_CYC : RES_LIM;
  localparam int RES_EFF     = (RES_EFF0 < 1) ? 1 : RES_EFF0;
  localparam int TSUS_EFF    = (TSUS_CYC < 1) ? 1 : TSUS_CYC;
  localparam int SYNC_EFF    = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic             cmd_valid;
  logic [CMD_W-1:0] cmd_code;
  logic             load, run, last;

  fsr_cmd_rx #(
    .SYNC_STAGES (SYNC_EFF),
    .CMD_BITS    (CMD_W)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .si_i        (si_i),
    .cmd_valid_o (cmd_valid),
    .cmd_code_o  (cmd_code)
  );

  fsr_ctrl #(
    .TSUS_CYC (TSUS_EFF),
    .TRES_CYC (RES_EFF),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_code_i  (cmd_code),
    .start_i     (op_start_i),
    .len_i       (op_len_i),
    .last_i      (last),
    .load_o      (load),
    .run_o       (run),
    .wip_o       (wip_o),
    .sus_o       (sus_o)
  );

  fsr_engine #(
    .LEN_W (LEN_W)
  ) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (op_len_i),
    .run_i  (run),
    .last_o (last),
    .done_o (done_o)
  );

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wip_o && sus_o));
endmodule

// File: tb/flash_susp_ctrl_tb_top.sv
module flash_susp_ctrl_tb_top;
  localparam int TSUS  = 20;
  localparam int TRES  = 40;
  localparam int TRES2 = 50;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic wip, sus, done, wip2, sus2, done2;

  int n_chk = 0, n_fail = 0, cyc = 0, wip_hi = 0;
  int ms = 0, mrem = 0, mw = 0;
  logic mdone = 1'b0, model_on = 1'b0, m_cmd_v = 1'b0, finished = 1'b0;
  logic [7:0] m_cmd_b = '0;

  always #2 clk = ~clk; // 4 ns period

  flash_susp_ctrl #(.TSUS_CYC(TSUS), .RES_DLY_CYC(TRES), .CLK_PS(4000), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .si_i(si),
    .op_start_i(start), .op_len_i(len), .wip_o(wip), .sus_o(sus), .done_o(done));

  flash_susp_ctrl #(.TSUS_CYC(TSUS), .RES_DLY_CYC(80), .CLK_PS(4000), .LEN_W(LEN_W)) dut_clamp_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .si_i(si),
    .op_start_i(start), .op_len_i(len), .wip_o(wip2), .sus_o(sus2), .done_o(done2));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic string req_of(input int s);
    case (s)
      0: return "R2";
      1: return "R6";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  // reference model: 0 idle, 1 running, 2 pausing, 3 parked, 4 resuming
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = 0; mrem = 0; mw = 0; mdone = 1'b0;
    end else begin
      mdone = 1'b0;
      case (ms)
        0: if (start && len != 0) begin mrem = int'(len); ms = 1; end
        1: if (mrem == 1) begin mrem = 0; ms = 0; mdone = 1'b1; end
           else begin
             mrem--;
             if (m_cmd_v && m_cmd_b == 8'h75) begin ms = 2; mw = TSUS; end
           end
        2: if (mw == 1) ms = 3; else mw--;
        3: if (m_cmd_v && m_cmd_b == 8'h7A) begin ms = 4; mw = TRES; end
        default: if (mw == 1) ms = 1; else mw--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (wip) wip_hi++;
    if (model_on) begin
      chk(req_of(ms), int'(wip), int'(ms == 1 || ms == 2));
      chk(req_of(ms), int'(sus), int'(ms == 3));
      chk("R2", int'(done), int'(mdone));
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc == 180000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=<180000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic shift_bits(input logic [7:0] b, input int n);
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = (i < 8) ? b[7-i] : 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  // call at a negedge with cs_n just raised
  task automatic cmd_tail(input logic [7:0] b, input int n);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (n == 8) begin m_cmd_v = 1'b1; m_cmd_b = b; end
    @(negedge clk);
    m_cmd_v = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input int n);
    shift_bits(b, n);
    @(negedge clk) cs_n = 1'b1;
    cmd_tail(b, n);
  endtask

  task automatic start_op(input int l);
    @(negedge clk);
    start = 1'b1; len = LEN_W'(l);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int c, c2;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    chk("R10", int'(wip), 0); chk("R10", int'(sus), 0); chk("R10", int'(done), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk("R10", int'(wip | sus | done), 0);

    // R2 start and completion timing
    start_op(10);
    chk("R2", int'(wip), 1);
    c = 1; @(negedge clk);
    while (wip) begin c++; @(negedge clk); end
    chk("R2", c, 10);
    chk("R2", int'(done), 1);
    start_op(0);
    chk("R2", int'(wip), 0);

    // R3 pause, R4 repeat pause, R5 resume, R9 delay clamp, R6 total
    @(posedge clk) wip_hi = 0;
    start_op(200);
    repeat (20) @(negedge clk);
    send(8'h75, 8);
    chk("R3", int'(wip), 1); chk("R3", int'(sus), 0);
    c = 1; @(negedge clk);
    while (wip) begin c++; @(negedge clk); end
    chk("R3", c, TSUS);
    chk("R3", int'(sus), 1);
    send(8'h75, 8);
    chk("R4", int'(sus), 1); chk("R4", int'(wip), 0);
    send(8'h7A, 8);
    chk("R5", int'(sus), 0); chk("R5", int'(wip), 0);
    chk("R9", int'(sus2), 0);
    c = 1; c2 = 1;
    fork
      begin @(negedge clk); while (!wip)  begin c++;  @(negedge clk); end end
      begin @(negedge clk); while (!wip2) begin c2++; @(negedge clk); end end
    join
    chk("R5", c, TRES);
    chk("R9", c2, TRES2);
    chk("R9", int'(c2 * 4 <= 200), 1);
    wait_done();
    chk("R6", wip_hi, 200 + TSUS);
    repeat (20) @(negedge clk);

    // R7 resume with no pause active
    send(8'h7A, 8);
    chk("R7", int'(wip), 0); chk("R7", int'(sus), 0);
    @(posedge clk) wip_hi = 0;
    start_op(150);
    send(8'h7A, 8);
    chk("R7", int'(wip), 1); chk("R7", int'(sus), 0);
    wait_done();
    chk("R7", wip_hi, 150);

    // R1 framing, bit order and unknown codes
    @(posedge clk) wip_hi = 0;
    start_op(400);
    send(8'h75, 7);
    chk("R1", int'(wip), 1); chk("R1", int'(sus), 0);
    send(8'h75, 9);
    chk("R1", int'(wip), 1); chk("R1", int'(sus), 0);
    send(8'hAE, 8);
    chk("R1", int'(wip), 1); chk("R1", int'(sus), 0);
    send(8'h75, 8);
    repeat (TSUS) @(negedge clk);
    chk("R1", int'(sus), 1);
    send(8'h7A, 8);
    wait_done();
    chk("R6", wip_hi, 400 + TSUS);
    repeat (5) @(negedge clk);

    // R8 pause landing on the completion edge
    shift_bits(8'h75, 8);
    start = 1'b1; len = LEN_W'(3);
    @(negedge clk);
    start = 1'b0; cs_n = 1'b1;
    cmd_tail(8'h75, 8);
    chk("R8", int'(done), 1); chk("R8", int'(wip), 0);
    repeat (TSUS + 5) @(negedge clk);
    chk("R8", int'(sus), 0);
    // one cycle earlier the pause must park the operation
    shift_bits(8'h75, 8);
    start = 1'b1; len = LEN_W'(4);
    @(negedge clk);
    start = 1'b0; cs_n = 1'b1;
    cmd_tail(8'h75, 8);
    chk("R8", int'(wip), 1);
    repeat (TSUS) @(negedge clk);
    chk("R8", int'(sus), 1);
    send(8'h7A, 8);
    wait_done();

    // random mix checked by the model every cycle
    for (int it = 0; it < 150; it++) begin
      int act;
      act = int'($urandom_range(0, 4));
      case (act)
        0: start_op(int'($urandom_range(0, 150)));
        1: send(8'h75, 8);
        2: send(8'h7A, 8);
        3: send(8'($urandom), int'($urandom_range(6, 10)));
        default: repeat (int'($urandom_range(0, 100))) @(negedge clk);
      endcase
    end
    repeat (10) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule